// File: doc/BRIEF.md
# Dual Serial FIFO with Trigger-Level Interrupts

This block sits between a processor-side register port and the shift engine of a serial peripheral. It holds a transmit queue, which the processor fills and the engine drains, and a receive queue, which the engine fills and the processor drains. Each queue is eight words deep. Each has its own enable, a one-shot flush and a programmable trigger level. The trigger levels drive the interrupt and DMA request lines, so software or a DMA channel only steps in when a queue needs service.

The two trigger conditions have opposite senses. The transmit condition holds while the transmit queue holds no more than its threshold, so a threshold of zero waits for the queue to drain completely. The receive condition holds once the receive queue holds more than its threshold, so a threshold of zero fires on the first word. Two faults are recorded in sticky flags that software clears by writing one: a word the engine pushes into a full receive queue, which is dropped, and a word the engine requests from an empty transmit queue during an active transfer. Each of the four interrupt sources is enabled by a write-one-to-set register and disabled by a write-one-to-clear register.

The register port has seven addresses. Address 0 holds the configuration. Address 1 holds status and the error flags. Address 2 holds the trigger levels. Address 3 sets interrupt enables and address 4 clears them; reading either returns the current enables. A write to address 5 pushes a transmit word. A read of address 6 with `regRd` pops a receive word.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset both queues are empty and disabled, the transmit threshold is 0 and the receive threshold is 1, all interrupt enables and error flags are 0, and irq and both DMA requests are low. Configuration bits [11:8] read back DEPTH/8, which is 1 for depth 8.
- R2: While the transmit enable (configuration bit 0) is set, a write to address 5 queues a word. The engine receives the words in write order on engTxData, and engTxValid is high exactly when the queue is not empty. A pull with engTxReq removes the head word. A write to a full queue is dropped.
- R3: While the receive enable (configuration bit 1) is set, engRxPush stores engRxData. A read of address 6 with regRd returns the oldest word on regRdata and removes it, so words come out in arrival order.
- R4: A write to address 5 while the transmit enable is 0 has no effect, and a push from the engine while the receive enable is 0 has no effect.
- R5: A configuration write with bit 4 set empties the transmit queue, and one with bit 5 set empties the receive queue, by the next cycle. The enable bits carried in the same write take effect at the same time.
- R6: Status (address 1) reports transmit-not-full in bit 2, transmit-empty in bit 3 and receive-not-empty in bit 4.
- R7: Status bit 5, the transmit level condition, is 1 when the transmit enable is set and the transmit count is at or below the threshold in trigger bits [3:0].
- R8: Status bit 6, the receive level condition, is 1 when the receive enable is set and the receive count is at least the threshold in trigger bits [11:8] plus one.
- R9: An engine push into a full, enabled receive queue drops the word and sets the sticky receive error in status bit 1.
- R10: engTxReq with engActive high while the transmit queue is empty sets the sticky transmit error in status bit 0. The same request with engActive low has no effect.
- R11: Writing 1 to status bit 0 or bit 1 clears that error flag, and writing 0 leaves it unchanged. A new error in the same cycle as the clear wins over the clear.
- R12: A write to address 3 sets the interrupt enables selected by its bits, and a write to address 4 clears them: bit 0 transmit error, bit 1 receive error, bit 2 transmit level, bit 3 receive level. irq is the OR of each enabled source.
- R13: txDmaReq equals configuration bit 2 AND the transmit level condition, and rxDmaReq equals configuration bit 3 AND the receive level condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; pops the receive queue at address 6 |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| engActive | input | 1 | Engine is inside a transfer |
| engTxReq | input | 1 | Engine takes the head transmit word |
| engTxValid | output | 1 | Transmit queue holds a word |
| engTxData | output | DATA_W | Head transmit word |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxData | input | DATA_W | Received word |
| irq | output | 1 | Combined interrupt request |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
The embedded properties check, on every cycle, a set of invariants. Queue occupancy never exceeds the depth. A flush leaves the queue empty on the next cycle. A push into a full receive queue leaves its occupancy unchanged. An error flag rises only after the matching engine fault, and stays set until written with one. A cleared interrupt enable is low on the next cycle, and irq never rises while no enable is set. Data ordering, the exact threshold boundaries in both directions, the effect of the enables, the status encoding and the DMA gating need concrete sequences, and only the bench scenarios show them. In those scenarios scoreboard queues predict every word the engine and the processor should see.

// File: rtl/dfi_pkg.sv
package dfi_pkg;

  typedef enum logic [2:0] {
    REG_CFG    = 3'd0,
    REG_STAT   = 3'd1,
    REG_TRIG   = 3'd2,
    REG_INTSET = 3'd3,
    REG_INTCLR = 3'd4,
    REG_TXDATA = 3'd5,
    REG_RXDATA = 3'd6
  } regSel_e;

  // configuration bit positions
  localparam int CFG_TXEN    = 0;
  localparam int CFG_RXEN    = 1;
  localparam int CFG_TXDMA   = 2;
  localparam int CFG_RXDMA   = 3;
  localparam int CFG_TXFLUSH = 4;
  localparam int CFG_RXFLUSH = 5;
  localparam int CFG_SIZE_LO = 8;

  // status bit positions
  localparam int ST_TXERR   = 0;
  localparam int ST_RXERR   = 1;
  localparam int ST_TXNFULL = 2;
  localparam int ST_TXEMPTY = 3;
  localparam int ST_RXNEMPT = 4;
  localparam int ST_TXLVL   = 5;
  localparam int ST_RXLVL   = 6;

  // interrupt enable bit positions
  localparam int IE_TXERR = 0;
  localparam int IE_RXERR = 1;
  localparam int IE_TXLVL = 2;
  localparam int IE_RXLVL = 3;

  localparam int TRIG_RX_LO = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic txEn;
    logic rxEn;
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } dpStrobe_t;

  // fault pulses from datapath to control
  typedef struct packed {
    logic txUnder;
    logic rxOver;
  } dpEvent_t;

endpackage

// File: rtl/dfi_fifo.sv
module dfi_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             flush,
  input  logic                             push,
  input  logic                             pop,
  input  logic [WIDTH-1:0]                 wdata,
  output logic [WIDTH-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full,
  output logic                             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));

endmodule

// File: rtl/dfi_datapath.sv
module dfi_datapath
  import dfi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         engActive,
  input  logic                         engTxReq,
  output logic                         engTxValid,
  output logic [DATA_W-1:0]            engTxData,
  input  logic                         engRxPush,
  input  logic [DATA_W-1:0]            engRxData,
  output dpEvent_t                     ev,
  output logic [$clog2(DEPTH+1)-1:0]   txCount,
  output logic [$clog2(DEPTH+1)-1:0]   rxCount,
  output logic [DATA_W-1:0]            rxHead
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic rxPushQ;

  assign rxPushQ = engRxPush && stb.rxEn;

  dfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rstN  (rstN),
    .flush (stb.txFlush),
    .push  (stb.txPush),
    .pop   (engTxReq),
    .wdata (wrData),
    .rdata (engTxData),
    .count (txCount),
    .full  (txFull),
    .empty (txEmpty)
  );

  dfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rstN  (rstN),
    .flush (stb.rxFlush),
    .push  (rxPushQ),
    .pop   (stb.rxPop),
    .wdata (engRxData),
    .rdata (rxHead),
    .count (rxCount),
    .full  (rxFull),
    .empty (rxEmpty)
  );

  assign engTxValid = !txEmpty;
  assign ev.txUnder = engTxReq && engActive && txEmpty;
  assign ev.rxOver  = rxPushQ && rxFull;

  logic unusedFlags;
  assign unusedFlags = txFull ^ rxEmpty;

  // R9
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPushQ && rxFull && !stb.rxPop && !stb.rxFlush) |=> (rxCount == CNT_W'(DEPTH)));

  // R4
  rx_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rxEn && !stb.rxPop && !stb.rxFlush) |=> $stable(rxCount));

endmodule

// File: rtl/dfi_ctrl.sv
module dfi_ctrl
  import dfi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic                         regRd,
  input  logic [2:0]                   regAddr,
  input  logic [31:0]                  regWdata,
  output logic [31:0]                  regRdata,
  output dpStrobe_t                    stb,
  output logic [DATA_W-1:0]            wrData,
  input  dpEvent_t                     ev,
  input  logic [$clog2(DEPTH+1)-1:0]   txCount,
  input  logic [$clog2(DEPTH+1)-1:0]   rxCount,
  input  logic [DATA_W-1:0]            rxHead,
  output logic                         irq,
  output logic                         txDmaReq,
  output logic                         rxDmaReq
);
  localparam int CNT_W     = $clog2(DEPTH+1);
  localparam int TRIG_W    = CNT_W;
  localparam int SIZE_CODE = DEPTH / 8;

  logic              txEn, rxEn, txDmaEn, rxDmaEn;
  logic [TRIG_W-1:0] trigTx, trigRx;
  logic [3:0]        intEn;
  logic              txErr, rxErr;
  logic              txLvl, rxLvl;
  logic              wrCfg, wrStat, wrTrig, wrSet, wrClr, wrTx, rdRx;
  logic [31:0]       rxHeadExt;

  assign wrCfg  = regWr && (regAddr == REG_CFG);
  assign wrStat = regWr && (regAddr == REG_STAT);
  assign wrTrig = regWr && (regAddr == REG_TRIG);
  assign wrSet  = regWr && (regAddr == REG_INTSET);
  assign wrClr  = regWr && (regAddr == REG_INTCLR);
  assign wrTx   = regWr && (regAddr == REG_TXDATA);
  assign rdRx   = regRd && (regAddr == REG_RXDATA);

  assign wrData      = regWdata[DATA_W-1:0];
  assign stb.txEn    = txEn;
  assign stb.rxEn    = rxEn;
  assign stb.txPush  = wrTx && txEn;
  assign stb.rxPop   = rdRx;
  assign stb.txFlush = wrCfg && regWdata[CFG_TXFLUSH];
  assign stb.rxFlush = wrCfg && regWdata[CFG_RXFLUSH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
      txDmaEn <= 1'b0;
      rxDmaEn <= 1'b0;
      trigTx  <= '0;
      trigRx  <= TRIG_W'(1);
      intEn   <= '0;
      txErr   <= 1'b0;
      rxErr   <= 1'b0;
    end else begin
      if (wrCfg) begin
        txEn    <= regWdata[CFG_TXEN];
        rxEn    <= regWdata[CFG_RXEN];
        txDmaEn <= regWdata[CFG_TXDMA];
        rxDmaEn <= regWdata[CFG_RXDMA];
      end
      if (wrTrig) begin
        trigTx <= regWdata[TRIG_W-1:0];
        trigRx <= regWdata[TRIG_RX_LO +: TRIG_W];
      end
      if (wrSet)      intEn <= intEn | regWdata[3:0];
      else if (wrClr) intEn <= intEn & ~regWdata[3:0];
      txErr <= (txErr && !(wrStat && regWdata[ST_TXERR])) || ev.txUnder;
      rxErr <= (rxErr && !(wrStat && regWdata[ST_RXERR])) || ev.rxOver;
    end
  end

  assign txLvl = txEn && (txCount <= trigTx);
  assign rxLvl = rxEn && (rxCount > trigRx);

  assign irq = (intEn[IE_TXERR] && txErr) || (intEn[IE_RXERR] && rxErr) ||
               (intEn[IE_TXLVL] && txLvl) || (intEn[IE_RXLVL] && rxLvl);
  assign txDmaReq = txDmaEn && txLvl;
  assign rxDmaReq = rxDmaEn && rxLvl;

  generate
    if (DATA_W < 32) begin : g_pad
      assign rxHeadExt = {{(32-DATA_W){1'b0}}, rxHead};
    end else begin : g_trunc
      assign rxHeadExt = rxHead[31:0];
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CFG: begin
        regRdata[CFG_TXEN]  = txEn;
        regRdata[CFG_RXEN]  = rxEn;
        regRdata[CFG_TXDMA] = txDmaEn;
        regRdata[CFG_RXDMA] = rxDmaEn;
        regRdata[CFG_SIZE_LO +: 4] = 4'(SIZE_CODE);
      end
      REG_STAT: begin
        regRdata[ST_TXERR]   = txErr;
        regRdata[ST_RXERR]   = rxErr;
        regRdata[ST_TXNFULL] = (txCount != CNT_W'(DEPTH));
        regRdata[ST_TXEMPTY] = (txCount == '0);
        regRdata[ST_RXNEMPT] = (rxCount != '0);
        regRdata[ST_TXLVL]   = txLvl;
        regRdata[ST_RXLVL]   = rxLvl;
      end
      REG_TRIG: begin
        regRdata[TRIG_W-1:0]             = trigTx;
        regRdata[TRIG_RX_LO +: TRIG_W]   = trigRx;
      end
      REG_INTSET, REG_INTCLR: regRdata[3:0] = intEn;
      REG_RXDATA: regRdata = (rxCount != '0) ? rxHeadExt : '0;
      default: regRdata = '0;
    endcase
  end

  logic unusedWdata;
  assign unusedWdata = ^regWdata;

  // R10
  tx_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txErr) |-> $past(ev.txUnder));

  // R9
  rx_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxErr) |-> $past(ev.rxOver));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !(wrStat && regWdata[ST_TXERR])) |=> txErr);

  // R12
  int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && regWdata[IE_TXLVL]) |=> !intEn[IE_TXLVL]);

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intEn != '0));

endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
  import dfi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              engActive,
  input  logic              engTxReq,
  output logic              engTxValid,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  dpStrobe_t         stb;
  dpEvent_t          ev;
  logic [DATA_W-1:0] wrData, rxHead;
  logic [CNT_W-1:0]  txCount, rxCount;

  dfi_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .stb      (stb),
    .wrData   (wrData),
    .ev       (ev),
    .txCount  (txCount),
    .rxCount  (rxCount),
    .rxHead   (rxHead),
    .irq      (irq),
    .txDmaReq (txDmaReq),
    .rxDmaReq (rxDmaReq)
  );

  dfi_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .engActive  (engActive),
    .engTxReq   (engTxReq),
    .engTxValid (engTxValid),
    .engTxData  (engTxData),
    .engRxPush  (engRxPush),
    .engRxData  (engRxData),
    .ev         (ev),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .rxHead     (rxHead)
  );

endmodule

// File: tb/dual_fifo_irq_bench.sv
module dual_fifo_irq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        engActive = 1'b0, engTxReq = 1'b0, engTxValid;
  logic [15:0] engTxData, engRxData = '0;
  logic        engRxPush = 1'b0;
  logic        irq, txDmaReq, rxDmaReq;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [15:0] txQ[$];
  logic [15:0] rxQ[$];
  logic [31:0] rd;

  always #4 clk = ~clk;

  dual_fifo_irq u_dual_fifo_irq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engActive(engActive),
    .engTxReq(engTxReq), .engTxValid(engTxValid), .engTxData(engTxData),
    .engRxPush(engRxPush), .engRxData(engRxData), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // driver: processor-side transmit write, scoreboard records accepted words
  task automatic cpuTx(input logic [15:0] w, input bit accept);
    regWrite(3'd5, {16'h0, w});
    if (accept) txQ.push_back(w);
  endtask

  // monitor: engine pull, compared against the scoreboard head
  task automatic engPull();
    engTxReq = 1'b1; engActive = 1'b1;
    #1;
    if (txQ.size() > 0) begin
      chk("R2 valid", {31'h0, engTxValid}, 32'h1);
      chk("R2 order", {16'h0, engTxData}, {16'h0, txQ.pop_front()});
    end else begin
      chk("R2 valid-empty", {31'h0, engTxValid}, 32'h0);
    end
    @(negedge clk);
    engTxReq = 1'b0; engActive = 1'b0;
  endtask

  task automatic engPush(input logic [15:0] w, input bit accept);
    engRxPush = 1'b1; engRxData = w;
    @(negedge clk);
    engRxPush = 1'b0;
    if (accept) rxQ.push_back(w);
  endtask

  task automatic cpuPop();
    logic [15:0] e;
    regAddr = 3'd6; regRd = 1'b1;
    #1;
    e = rxQ.pop_front();
    chk("R3 order", regRdata, {16'h0, e});
    @(negedge clk);
    regRd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(3'd0, rd); chk("R1 cfg", rd, 32'h100);
    regRead(3'd1, rd); chk("R1 stat", rd, 32'h0C);
    regRead(3'd2, rd); chk("R1 trig", rd, 32'h100);
    regRead(3'd3, rd); chk("R1 inten", rd, 32'h0);
    chk("R1 outs", {29'h0, irq, txDmaReq, rxDmaReq}, 32'h0);

    // R4 disabled queues ignore producers
    cpuTx(16'h0011, 1'b0);
    regRead(3'd1, rd); chk("R4 tx disabled", rd, 32'h0C);
    engPush(16'h0022, 1'b0);
    regRead(3'd1, rd); chk("R4 rx disabled", rd, 32'h0C);

    // enable both; R7 empty tx with threshold 0
    regWrite(3'd0, 32'h3);
    regRead(3'd1, rd); chk("R7 empty level", rd, 32'h2C);

    // R2 fill, overflow drop, drain; R6 status
    for (int i = 0; i < 8; i++) cpuTx(16'hA0 + 16'(i), 1'b1);
    regRead(3'd1, rd); chk("R6 tx full", rd, 32'h00);
    cpuTx(16'h00FF, 1'b0);
    for (int i = 0; i < 8; i++) engPull();
    regRead(3'd1, rd); chk("R6 tx drained", rd, 32'h2C);

    // R7 threshold 3 boundary
    regWrite(3'd2, 32'h103);
    for (int i = 0; i < 3; i++) cpuTx(16'hB0 + 16'(i), 1'b1);
    regRead(3'd1, rd); chk("R7 at threshold", rd, 32'h24);
    cpuTx(16'hB3, 1'b1);
    regRead(3'd1, rd); chk("R7 above threshold", rd, 32'h04);
    for (int i = 0; i < 4; i++) engPull();

    // R10 underflow only while active
    engTxReq = 1'b1; engActive = 1'b0;
    @(negedge clk);
    engTxReq = 1'b0;
    regRead(3'd1, rd); chk("R10 inactive", rd, 32'h2C);
    engPull();
    regRead(3'd1, rd); chk("R10 underflow", rd, 32'h2D);
    // R11 write-one-to-clear
    regWrite(3'd1, 32'h0);
    regRead(3'd1, rd); chk("R11 write zero", rd, 32'h2D);
    regWrite(3'd1, 32'h1);
    regRead(3'd1, rd); chk("R11 write one", rd, 32'h2C);

    // R8 receive threshold
    regWrite(3'd2, 32'h100);
    engPush(16'h0301, 1'b1);
    regRead(3'd1, rd); chk("R8 one below", rd, 32'h3C);
    regWrite(3'd2, 32'h000);
    regRead(3'd1, rd); chk("R8 threshold zero", rd, 32'h7C);
    regWrite(3'd2, 32'h100);
    engPush(16'h0302, 1'b1);
    regRead(3'd1, rd); chk("R8 two entries", rd, 32'h7C);
    for (int i = 3; i <= 8; i++) engPush(16'h0300 + 16'(i), 1'b1);
    // R9 overflow drops and flags
    engPush(16'h03FF, 1'b0);
    regRead(3'd1, rd); chk("R9 overflow", rd, 32'h7E);
    for (int i = 0; i < 8; i++) cpuPop();
    regRead(3'd1, rd); chk("R3 rx drained", rd, 32'h2E);
    regWrite(3'd1, 32'h2);
    regRead(3'd1, rd); chk("R11 rx clear", rd, 32'h2C);

    // R12 interrupt enables
    regWrite(3'd3, 32'h4);
    regRead(3'd3, rd); chk("R12 set", rd, 32'h4);
    #1 chk("R12 tx level irq", {31'h0, irq}, 32'h1);
    regWrite(3'd4, 32'h4);
    regRead(3'd4, rd); chk("R12 clear", rd, 32'h0);
    #1 chk("R12 irq off", {31'h0, irq}, 32'h0);
    regWrite(3'd3, 32'h2);
    #1 chk("R12 rx err masked", {31'h0, irq}, 32'h0);
    regWrite(3'd3, 32'h1);
    engPull();
    #1 chk("R12 tx err irq", {31'h0, irq}, 32'h1);
    regWrite(3'd1, 32'h1);
    #1 chk("R12 err cleared", {31'h0, irq}, 32'h0);
    regWrite(3'd3, 32'h8);
    engPush(16'h0401, 1'b1);
    #1 chk("R12 rx below level", {31'h0, irq}, 32'h0);
    engPush(16'h0402, 1'b1);
    #1 chk("R12 rx level irq", {31'h0, irq}, 32'h1);
    regRead(3'd3, rd); chk("R12 readback", rd, 32'hB);

    // R13 DMA gating
    regWrite(3'd0, 32'h7);
    #1 chk("R13 tx dma", {30'h0, txDmaReq, rxDmaReq}, 32'h2);
    regWrite(3'd0, 32'hB);
    #1 chk("R13 rx dma", {30'h0, txDmaReq, rxDmaReq}, 32'h1);

    // R5 flush
    regWrite(3'd0, 32'h23);
    rxQ.delete();
    regRead(3'd1, rd); chk("R5 rx flush", rd, 32'h2C);
    regWrite(3'd5, 32'h0501);
    regWrite(3'd5, 32'h0502);
    regRead(3'd1, rd); chk("R5 tx loaded", rd, 32'h04);
    regWrite(3'd0, 32'h13);
    regRead(3'd1, rd); chk("R5 tx flush", rd, 32'h2C);
    regRead(3'd0, rd); chk("R5 enables kept", rd, 32'h103);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule